// File: doc/BRIEF.md
# Three-level transition line coder

This block turns a binary bit stream into a three-level line signal and turns such a signal back into bits. The encoder accepts one bit per symbol clock and emits one signed level per accepted bit. A 1 moves the level one step along the fixed cycle 0, +1, 0, -1, 0, and so on. A 0 leaves the level where it is. The encoder tracks which way the next step away from zero goes with a direction flag. The flag is raised when the level reaches +1 and lowered when it reaches -1.

The decoder accepts already-sliced three-level symbols. It emits a 1 whenever a symbol differs from the previous accepted symbol, and a 0 when the two are equal. Each half has one register stage of latency, and each output carries a valid strobe that follows the matching input valid. A synchronous reset returns both halves to level zero. Because the reset level is the same on both sides, a decoder fed straight from the encoder reproduces the input bits two cycles later.

Top module: `tlc_codec`

## Requirements
- R1: While reset is high and on the cycle after it falls, encLevel is 2'b00, encLevelValid is 0, decBit is 0 and decBitValid is 0.
- R2: An accepted input bit of 0 (encValid high, encBit 0) leaves encLevel unchanged on the next cycle.
- R3: Starting from reset, accepted 1 bits drive encLevel through +1, 0, -1, 0, +1, 0, -1, 0, one step per accepted 1, visible one cycle after the bit is accepted. From +1 or -1 a 1 always goes to 0.
- R4: From level 0, an accepted 1 goes to -1 if the most recent nonzero level was +1, and to +1 if it was -1 or if there has been none since reset. Intervening 0 bits do not change this choice, and +1 never moves straight to -1.
- R5: Levels are two's complement on 2 bits: 2'b01 = +1, 2'b00 = 0, 2'b11 = -1. encLevel never takes the value 2'b10.
- R6: encLevelValid equals encValid of the previous cycle. While encValid is low, encBit is ignored and encLevel holds.
- R7: One cycle after decValid is high, decBitValid is high and decBit is 1 if decLevel differed from the previous accepted symbol and 0 if it was equal. The previous symbol after reset is 2'b00. One cycle after decValid is low, decBitValid is low.
- R8: Symbols presented while decValid is low are ignored. They change neither decBit nor the stored previous symbol.
- R9: With encLevel and encLevelValid wired to decLevel and decValid, decBit reproduces the accepted encBit stream with a delay of two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous reset, active high |
| encValid | input | 1 | Encoder input bit is present |
| encBit | input | 1 | Encoder input bit |
| encLevel | output | 2 | Encoded level, two's complement |
| encLevelValid | output | 1 | encLevel carries a new symbol |
| decValid | input | 1 | Decoder input symbol is present |
| decLevel | input | 2 | Received sliced level, two's complement |
| decBit | output | 1 | Recovered bit |
| decBitValid | output | 1 | decBit carries a new bit |

## Verification
The hardest state to reach from the ports is a level of zero with the direction flag set, followed by a run of 0 bits and stalled cycles before the next 1. Only that sequence shows that the flag survives idle time and sends the next step to -1 rather than +1. The directed stimulus reaches it by sending a 1 to reach +1 and a 1 to return to zero. It then mixes accepted zeros with cycles where encValid is low and encBit is 1, and only then sends the deciding 1. On the decoder side, the matching hard case is an ignored symbol that differs from the stored one. It is followed by a valid symbol equal to the last valid one, which must decode as 0.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int LVL_W = 2;

  typedef logic signed [LVL_W-1:0] level_t;

  localparam level_t LVL_POS  = 2'sb01;
  localparam level_t LVL_ZERO = 2'sb00;
  localparam level_t LVL_NEG  = 2'sb11;

  // Strobes from control to the two datapaths
  typedef struct packed {
    logic encClear;
    logic encLoad;
    logic encStep;
    logic decClear;
    logic decLoad;
  } strobe_t;
endpackage

// File: rtl/tlc_ctrl.sv
module tlc_ctrl
  import tlc_pkg::*;
(
  input  logic    rst,
  input  logic    encValid,
  input  logic    encBit,
  input  logic    decValid,
  output strobe_t strb
);
  always_comb begin
    strb          = '0;
    strb.encClear = rst;
    strb.decClear = rst;
    strb.encLoad  = !rst && encValid;
    strb.encStep  = !rst && encValid && encBit;
    strb.decLoad  = !rst && decValid;
  end
endmodule

// File: rtl/tlc_enc_dp.sv
module tlc_enc_dp
  import tlc_pkg::*;
(
  input  logic    clk,
  input  strobe_t strb,
  output level_t  levelQ,
  output logic    validQ,
  output logic    dirDownQ
);
  level_t levelNext;
  logic   dirNext;

  // Next level on a 1: away from zero by the flag, else back to zero
  always_comb begin
    unique case (levelQ)
      LVL_ZERO: levelNext = dirDownQ ? LVL_NEG : LVL_POS;
      default:  levelNext = LVL_ZERO;
    endcase
  end

  always_comb begin
    if (levelNext == LVL_POS)      dirNext = 1'b1;
    else if (levelNext == LVL_NEG) dirNext = 1'b0;
    else                           dirNext = dirDownQ;
  end

  always_ff @(posedge clk) begin
    if (strb.encClear) begin
      levelQ   <= LVL_ZERO;
      dirDownQ <= 1'b0;
      validQ   <= 1'b0;
    end else begin
      validQ <= strb.encLoad;
      if (strb.encStep) begin
        levelQ   <= levelNext;
        dirDownQ <= dirNext;
      end
    end
  end
endmodule

// File: rtl/tlc_dec_dp.sv
module tlc_dec_dp
  import tlc_pkg::*;
(
  input  logic    clk,
  input  strobe_t strb,
  input  level_t  levelIn,
  output logic    bitQ,
  output logic    validQ
);
  level_t prevQ;

  always_ff @(posedge clk) begin
    if (strb.decClear) begin
      prevQ  <= LVL_ZERO;
      bitQ   <= 1'b0;
      validQ <= 1'b0;
    end else begin
      validQ <= strb.decLoad;
      if (strb.decLoad) begin
        bitQ  <= (levelIn != prevQ);
        prevQ <= levelIn;
      end
    end
  end
endmodule

// File: rtl/tlc_codec.sv
module tlc_codec
  import tlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       encValid,
  input  logic       encBit,
  output logic [1:0] encLevel,
  output logic       encLevelValid,
  input  logic       decValid,
  input  logic [1:0] decLevel,
  output logic       decBit,
  output logic       decBitValid
);
  strobe_t strb;
  level_t  encLevelQ;
  logic    encDirDown;

  tlc_ctrl u_ctrl (
    .rst      (rst),
    .encValid (encValid),
    .encBit   (encBit),
    .decValid (decValid),
    .strb     (strb)
  );

  tlc_enc_dp u_enc (
    .clk      (clk),
    .strb     (strb),
    .levelQ   (encLevelQ),
    .validQ   (encLevelValid),
    .dirDownQ (encDirDown)
  );

  tlc_dec_dp u_dec (
    .clk     (clk),
    .strb    (strb),
    .levelIn (level_t'(decLevel)),
    .bitQ    (decBit),
    .validQ  (decBitValid)
  );

  assign encLevel = encLevelQ;
endmodule

// File: rtl/tlc_codec_chk.sv
module tlc_codec_chk (
  input logic       clk,
  input logic       rst,
  input logic       encValid,
  input logic       encBit,
  input logic [1:0] encLevel,
  input logic       encLevelValid,
  input logic       encDirDown,
  input logic       decValid,
  input logic       decBit,
  input logic       decBitValid
);
  p_legal_level_r5: assert property (@(posedge clk) disable iff (rst)
    encLevel != 2'b10);

  p_hold_on_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (encValid && !encBit) |=> (encLevel == $past(encLevel)));

  p_return_to_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (encValid && encBit && encLevel != 2'b00) |=> (encLevel == 2'b00));

  p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
    (encValid && encBit && encLevel == 2'b00 && encDirDown) |=> (encLevel == 2'b11));

  p_step_up_r4: assert property (@(posedge clk) disable iff (rst)
    (encValid && encBit && encLevel == 2'b00 && !encDirDown) |=> (encLevel == 2'b01));

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !encValid |=> ($stable(encLevel) && !encLevelValid));

  p_valid_follow_r6: assert property (@(posedge clk) disable iff (rst)
    encValid |=> encLevelValid);

  p_dec_valid_r7: assert property (@(posedge clk) disable iff (rst)
    decValid |=> decBitValid);

  p_dec_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    !decValid |=> ($stable(decBit) && !decBitValid));
endmodule

bind tlc_codec tlc_codec_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .encValid      (encValid),
  .encBit        (encBit),
  .encLevel      (encLevel),
  .encLevelValid (encLevelValid),
  .encDirDown    (encDirDown),
  .decValid      (decValid),
  .decBit        (decBit),
  .decBitValid   (decBitValid)
);

// File: tb/tlc_codec_tb_top.sv
module tlc_codec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       encValid = 1'b0;
  logic       encBit = 1'b0;
  logic [1:0] encLevel;
  logic       encLevelValid;
  logic       decValid = 1'b0;
  logic [1:0] decLevel = 2'b00;
  logic       decBit;
  logic       decBitValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench-side model of the encoder
  logic [1:0] expLevel;
  bit         expDown;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlc_codec dut_i (
    .clk(clk), .rst(rst),
    .encValid(encValid), .encBit(encBit),
    .encLevel(encLevel), .encLevelValid(encLevelValid),
    .decValid(decValid), .decLevel(decLevel),
    .decBit(decBit), .decBitValid(decBitValid)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelStep(bit b);
    if (b) begin
      if (expLevel != 2'b00) expLevel = 2'b00;
      else expLevel = expDown ? 2'b11 : 2'b01;
      if (expLevel == 2'b01) expDown = 1'b1;
      if (expLevel == 2'b11) expDown = 1'b0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; encValid = 1'b0; encBit = 1'b0; decValid = 1'b0; decLevel = 2'b00;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    expLevel = 2'b00; expDown = 1'b0;
  endtask

  // Present one encoder input, then sample the result one cycle later
  task automatic sendBit(bit v, bit b);
    encValid = v; encBit = b;
    if (v) modelStep(b);
    @(negedge clk);
    encValid = 1'b0; encBit = 1'b0;
  endtask

  task automatic sendSym(bit v, logic [1:0] s);
    decValid = v; decLevel = s;
    @(negedge clk);
    decValid = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "encLevel in reset", encLevel, 0);
    check("R1", "encLevelValid in reset", encLevelValid, 0);
    check("R1", "decBit in reset", decBit, 0);
    check("R1", "decBitValid in reset", decBitValid, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "encLevel after reset", encLevel, 0);
    check("R1", "decBitValid after reset", decBitValid, 0);
    expLevel = 2'b00; expDown = 1'b0;
  endtask

  // R3 and R5: full level cycle with the two's complement codes
  task automatic testCycle();
    logic [1:0] seq [8] = '{2'b01, 2'b00, 2'b11, 2'b00, 2'b01, 2'b00, 2'b11, 2'b00};
    doReset();
    for (int i = 0; i < 8; i++) begin
      sendBit(1'b1, 1'b1);
      check("R3", "cycle level", encLevel, seq[i]);
      check("R5", "level code matches model", encLevel, expLevel);
      check("R6", "valid follows", encLevelValid, 1);
    end
  endtask

  // R2 and R4: zeros hold, direction survives zeros and stalls
  task automatic testZerosAndDirection();
    doReset();
    sendBit(1'b1, 1'b1);
    sendBit(1'b1, 1'b0);
    check("R2", "hold +1 on zero", encLevel, 2'b01);
    sendBit(1'b1, 1'b0);
    check("R2", "hold +1 on second zero", encLevel, 2'b01);
    sendBit(1'b1, 1'b1);
    check("R3", "back to zero", encLevel, 2'b00);
    sendBit(1'b1, 1'b0);
    sendBit(1'b0, 1'b1);
    sendBit(1'b1, 1'b0);
    check("R2", "hold zero", encLevel, 2'b00);
    sendBit(1'b1, 1'b1);
    check("R4", "zero to -1 after +1", encLevel, 2'b11);
    sendBit(1'b1, 1'b1);
    sendBit(1'b0, 1'b1);
    sendBit(1'b1, 1'b0);
    sendBit(1'b1, 1'b1);
    check("R4", "zero to +1 after -1", encLevel, 2'b01);
  endtask

  // R6: invalid cycles are ignored
  task automatic testStall();
    doReset();
    sendBit(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) begin
      sendBit(1'b0, 1'b1);
      check("R6", "level holds while stalled", encLevel, 2'b01);
      check("R6", "valid low while stalled", encLevelValid, 0);
    end
    sendBit(1'b1, 1'b1);
    check("R6", "resumes after stall", encLevel, 2'b00);
  endtask

  // R7: direct decoder stimulus
  task automatic testDecoder();
    logic [1:0] syms [7] = '{2'b00, 2'b01, 2'b01, 2'b00, 2'b11, 2'b11, 2'b00};
    bit         bits [7] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    doReset();
    for (int i = 0; i < 7; i++) begin
      sendSym(1'b1, syms[i]);
      check("R7", "decoded bit", decBit, bits[i]);
      check("R7", "decoded valid", decBitValid, 1);
    end
    @(negedge clk);
    check("R7", "valid drops when idle", decBitValid, 0);
  endtask

  // R8: ignored symbols neither change output nor stored symbol
  task automatic testDecIgnore();
    doReset();
    sendSym(1'b1, 2'b01);
    check("R8", "setup bit", decBit, 1);
    sendSym(1'b0, 2'b11);
    check("R8", "bit unchanged on ignored symbol", decBit, 1);
    check("R8", "valid low on ignored symbol", decBitValid, 0);
    sendSym(1'b0, 2'b00);
    sendSym(1'b1, 2'b01);
    check("R8", "compare against last valid symbol", decBit, 0);
  endtask

  // R9: loopback with two-cycle delay
  task automatic testRoundTrip();
    bit hist [$];
    logic [7:0] lfsr = 8'hA5;
    doReset();
    for (int i = 0; i < 48; i++) begin
      bit b;
      b = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[4], lfsr[7:1]};
      if (i >= 2) begin
        check("R9", "loopback valid", decBitValid, 1);
        check("R9", "loopback bit", decBit, hist[i-2]);
      end
      hist.push_back(b);
      decLevel = encLevel; decValid = encLevelValid;
      encValid = 1'b1; encBit = b;
      @(negedge clk);
    end
    encValid = 1'b0; decValid = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    expLevel = 2'b00; expDown = 1'b0;
    testReset();
    testCycle();
    testZerosAndDirection();
    testStall();
    testDecoder();
    testDecIgnore();
    testRoundTrip();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule